// File: doc/BRIEF.md
# Wavefront Issue Scheduler

This block decides, cycle by cycle, which resident thread group of a compute cluster is sent to instruction issue next. The cluster has a set of vector SIMD units, and each unit owns a fixed number of wavefront slots. A wavefront is allocated into one named slot of one SIMD with its start program counter. It stays bound to that SIMD until it is freed. While it waits for a memory load it can be flagged as pending, and it is then passed over.

The scheduler serves one SIMD per pick, in strict rotation. Within the served SIMD it scans the slots with a round-robin pointer and takes the first slot that is allocated and not pending. It then presents the SIMD index, the slot index and the slot's program counter on a registered valid/ready output. A SIMD with nothing ready yields an empty pick, and the rotation still moves on. With four SIMDs, every unit therefore sees at most one new issue every four cycles, which matches the four cycles a wavefront instruction occupies a 16-lane unit.

Top module: `wave_issue_sched`

## Requirements
- R1: Each pick serves the SIMD that follows the previously served one (0, 1, 2, 3, 0, ...). After reset the first pick serves SIMD 0, and a pick is made in every cycle in which the output register is empty or being accepted.
- R2: Two new issues to the same SIMD are at least 4 cycles apart.
- R3: An issued slot was allocated and not pending in the cycle the pick was made, and `issue_pc` equals the start PC given when that slot was allocated.
- R4: Within a SIMD, the search starts at the slot after the one last issued from that SIMD and wraps around, so ready slots are taken in turn. After reset the search of every SIMD starts at slot 0.
- R5: When the served SIMD has no ready slot, `issue_valid` is 0 for that pick and the next pick serves the next SIMD.
- R6: A pending set excludes the slot from picks, and a pending clear makes it eligible again. When a set and a clear hit the same slot in one cycle, the slot ends up not pending.
- R7: An allocation request to a SIMD whose slots are all occupied raises `alloc_err` for exactly one cycle, starting the cycle after the request, and changes no slot.
- R8: An allocation to an already occupied slot, or to a slot index of `SLOTS` or more, is ignored, and the slot keeps its former PC.
- R9: Freeing a slot removes it from all later picks until it is allocated again.
- R10: While `issue_valid` is 1 and `issue_ready` is 0, the outputs hold their values and the rotation and slot pointers do not move.
- R11: In reset, `issue_valid` and `alloc_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate request |
| alloc_simd | input | SW | SIMD of the new wavefront |
| alloc_slot | input | LW | Slot of the new wavefront |
| alloc_pc | input | PC_W | Start program counter |
| alloc_err | output | 1 | Allocation refused, SIMD full |
| free_valid | input | 1 | Free request |
| free_simd | input | SW | SIMD of the slot to free |
| free_slot | input | LW | Slot to free |
| pend_set_valid | input | 1 | Mark a slot as waiting on memory |
| pend_set_simd | input | SW | SIMD for the pending set |
| pend_set_slot | input | LW | Slot for the pending set |
| pend_clr_valid | input | 1 | Memory result returned for a slot |
| pend_clr_simd | input | SW | SIMD for the pending clear |
| pend_clr_slot | input | LW | Slot for the pending clear |
| issue_valid | output | 1 | A pick is presented |
| issue_simd | output | SW | SIMD of the pick |
| issue_slot | output | LW | Slot of the pick |
| issue_pc | output | PC_W | Program counter of the picked slot |
| issue_ready | input | 1 | Consumer accepts the pick |

## Verification
Two functions can meet in one cycle: a pending set and a pending clear aimed at the same slot, and a pending set that lands in the very cycle in which that slot is being picked. The bench provokes both, first in directed sequences and then with random stimulus that keeps all request ports busy while the consumer stalls at random. It judges them by the later issue stream. After a combined set and clear the slot must reappear in its SIMD's turn. A set in the cycle of its own pick must not cancel that pick, because the pick is taken from the state before the edge, but it must exclude the slot from the following turns.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int WIS_SIMDS = 4;
  localparam int WIS_SLOTS = 10;
  localparam int WIS_PC_W  = 48;
  localparam int WIS_ISSUE_CYCLES = 4;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int N  = 10,
  parameter int LW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] last,
  output logic          found,
  output logic [LW-1:0] idx
);
  always_comb begin
    int c;
    found = 1'b0;
    idx   = '0;
    for (int k = N; k >= 1; k--) begin
      c = (int'(last) + k) % N;
      if (req[c]) begin
        found = 1'b1;
        idx   = LW'(c);
      end
    end
  end
endmodule

// File: rtl/wis_slot_state.sv
module wis_slot_state #(
  parameter int TOT = 40,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc_we,
  input  logic [AW-1:0]  alloc_addr,
  input  logic           free_we,
  input  logic [AW-1:0]  free_addr,
  input  logic           set_we,
  input  logic [AW-1:0]  set_addr,
  input  logic           clr_we,
  input  logic [AW-1:0]  clr_addr,
  output logic [TOT-1:0] valid_all,
  output logic [TOT-1:0] pend_all
);
  for (genvar i = 0; i < TOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_all[i] <= 1'b0;
        pend_all[i]  <= 1'b0;
      end else begin
        if (alloc_we && int'(alloc_addr) == i) begin
          valid_all[i] <= 1'b1;
          pend_all[i]  <= 1'b0;
        end
        if (set_we && int'(set_addr) == i) pend_all[i] <= 1'b1;
        if (clr_we && int'(clr_addr) == i) pend_all[i] <= 1'b0;
        if (free_we && int'(free_addr) == i) begin
          valid_all[i] <= 1'b0;
          pend_all[i]  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_SIMD = WIS_SIMDS,
  parameter int SLOTS    = WIS_SLOTS,
  parameter int PC_W     = WIS_PC_W,
  localparam int SW      = idx_w(NUM_SIMD),
  localparam int LW      = idx_w(SLOTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_valid,
  input  logic [SW-1:0]   alloc_simd,
  input  logic [LW-1:0]   alloc_slot,
  input  logic [PC_W-1:0] alloc_pc,
  output logic            alloc_err,
  input  logic            free_valid,
  input  logic [SW-1:0]   free_simd,
  input  logic [LW-1:0]   free_slot,
  input  logic            pend_set_valid,
  input  logic [SW-1:0]   pend_set_simd,
  input  logic [LW-1:0]   pend_set_slot,
  input  logic            pend_clr_valid,
  input  logic [SW-1:0]   pend_clr_simd,
  input  logic [LW-1:0]   pend_clr_slot,
  output logic            issue_valid,
  output logic [SW-1:0]   issue_simd,
  output logic [LW-1:0]   issue_slot,
  output logic [PC_W-1:0] issue_pc,
  input  logic            issue_ready
);
  localparam int TOT = NUM_SIMD * SLOTS;
  localparam int AW  = idx_w(TOT);

  function automatic logic in_range(input logic [SW-1:0] s, input logic [LW-1:0] l);
    return (int'(s) < NUM_SIMD) && (int'(l) < SLOTS);
  endfunction

  function automatic logic [AW-1:0] flat(input logic [SW-1:0] s, input logic [LW-1:0] l);
    return AW'(int'(s) * SLOTS + int'(l));
  endfunction

  logic [TOT-1:0] valid_all, pend_all;

  // allocation decode
  logic [SLOTS-1:0] alloc_row;
  logic             alloc_full, alloc_we;
  logic [AW-1:0]    alloc_addr;

  always_comb begin
    alloc_row  = (int'(alloc_simd) < NUM_SIMD) ? valid_all[int'(alloc_simd) * SLOTS +: SLOTS] : '0;
    alloc_full = (int'(alloc_simd) < NUM_SIMD) && ($countones(alloc_row) == SLOTS);
    alloc_addr = flat(alloc_simd, alloc_slot);
    alloc_we   = alloc_valid && in_range(alloc_simd, alloc_slot) && !valid_all[alloc_addr];
  end

  wis_slot_state #(.TOT(TOT), .AW(AW)) i_state (
    .clk       (clk),
    .rst       (rst),
    .alloc_we  (alloc_we),
    .alloc_addr(alloc_addr),
    .free_we   (free_valid && in_range(free_simd, free_slot)),
    .free_addr (flat(free_simd, free_slot)),
    .set_we    (pend_set_valid && in_range(pend_set_simd, pend_set_slot)),
    .set_addr  (flat(pend_set_simd, pend_set_slot)),
    .clr_we    (pend_clr_valid && in_range(pend_clr_simd, pend_clr_slot)),
    .clr_addr  (flat(pend_clr_simd, pend_clr_slot)),
    .valid_all (valid_all),
    .pend_all  (pend_all)
  );

  // rotation over SIMDs and per-SIMD slot pointer
  logic [SW-1:0]    turn;
  logic [LW-1:0]    rr_last [NUM_SIMD];
  logic [SLOTS-1:0] row_ready;
  logic             pick_found, load;
  logic [LW-1:0]    pick_slot;
  logic [AW-1:0]    pick_addr;

  always_comb begin
    row_ready = valid_all[int'(turn) * SLOTS +: SLOTS] & ~pend_all[int'(turn) * SLOTS +: SLOTS];
    load      = !issue_valid || issue_ready;
    pick_addr = flat(turn, pick_slot);
  end

  wis_rr_pick #(.N(SLOTS), .LW(LW)) i_pick (
    .req  (row_ready),
    .last (rr_last[turn]),
    .found(pick_found),
    .idx  (pick_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      turn        <= '0;
      issue_valid <= 1'b0;
      issue_simd  <= '0;
      issue_slot  <= '0;
      alloc_err   <= 1'b0;
      for (int s = 0; s < NUM_SIMD; s++) rr_last[s] <= LW'(SLOTS - 1);
    end else begin
      alloc_err <= alloc_valid && alloc_full;
      if (load) begin
        issue_valid <= pick_found;
        issue_simd  <= turn;
        issue_slot  <= pick_slot;
        turn        <= (int'(turn) == NUM_SIMD - 1) ? '0 : turn + 1'b1;
        if (pick_found) rr_last[turn] <= pick_slot;
      end
    end
  end

  // program counter store: one write port, one registered read port
  logic [PC_W-1:0] pc_mem [TOT];

  always_ff @(posedge clk) begin
    if (alloc_we) pc_mem[alloc_addr] <= alloc_pc;
    if (load) issue_pc <= pc_mem[pick_addr];
  end
endmodule

// File: rtl/wis_checker.sv
module wis_checker
  import wis_pkg::*;
#(
  parameter int NUM_SIMD = WIS_SIMDS,
  parameter int SLOTS    = WIS_SLOTS,
  parameter int PC_W     = WIS_PC_W,
  localparam int SW      = idx_w(NUM_SIMD),
  localparam int LW      = idx_w(SLOTS),
  localparam int TOT     = NUM_SIMD * SLOTS
) (
  input logic            clk,
  input logic            rst,
  input logic            alloc_valid,
  input logic            alloc_err,
  input logic            issue_valid,
  input logic            issue_ready,
  input logic [SW-1:0]   issue_simd,
  input logic [LW-1:0]   issue_slot,
  input logic [PC_W-1:0] issue_pc,
  input logic [TOT-1:0]  valid_all,
  input logic [TOT-1:0]  pend_all
);
  localparam int GAP = WIS_ISSUE_CYCLES;
  localparam int CW  = idx_w(GAP) + 1;

  logic           prev_hold, prev_load, started;
  logic [SW-1:0]  prev_simd;
  logic [TOT-1:0] ready_q;
  logic [CW-1:0]  since [NUM_SIMD];
  logic           new_issue;

  assign new_issue = issue_valid && !prev_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_hold <= 1'b0;
      prev_load <= 1'b0;
      started   <= 1'b0;
      prev_simd <= '0;
      ready_q   <= '0;
      for (int s = 0; s < NUM_SIMD; s++) since[s] <= CW'(GAP);
    end else begin
      prev_hold <= issue_valid && !issue_ready;
      prev_load <= !issue_valid || issue_ready;
      started   <= 1'b1;
      prev_simd <= issue_simd;
      ready_q   <= valid_all & ~pend_all;
      for (int s = 0; s < NUM_SIMD; s++) begin
        if (new_issue && int'(issue_simd) == s) since[s] <= '0;
        else if (int'(since[s]) < GAP) since[s] <= since[s] + 1'b1;
      end
    end
  end

  // R1: consecutive picks serve consecutive SIMDs
  a_r1_rotation: assert property (@(posedge clk) disable iff (rst)
    (started && prev_load && $past(started)) |->
      (int'(issue_simd) == ((int'(prev_simd) + 1) % NUM_SIMD)));

  // R2: new issues to one SIMD are at least GAP cycles apart
  a_r2_issue_gap: assert property (@(posedge clk) disable iff (rst)
    new_issue |-> (int'(since[issue_simd]) >= GAP - 1));

  // R3: an issued slot was ready when it was picked
  a_r3_ready_slot: assert property (@(posedge clk) disable iff (rst)
    new_issue |-> ready_q[int'(issue_simd) * SLOTS + int'(issue_slot)]);

  // R3: slot index stays within the slot count
  a_r3_slot_range: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (int'(issue_slot) < SLOTS));

  // R10: a stalled pick holds its outputs
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_ready) |=>
      (issue_valid && $stable(issue_simd) && $stable(issue_slot) && $stable(issue_pc)));

  // R7: the error flag follows an allocation request and lasts one cycle
  a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
    alloc_err |-> $past(alloc_valid));
endmodule

bind wave_issue_sched wis_checker #(
  .NUM_SIMD(NUM_SIMD), .SLOTS(SLOTS), .PC_W(PC_W)
) i_wis_checker (
  .clk        (clk),
  .rst        (rst),
  .alloc_valid(alloc_valid),
  .alloc_err  (alloc_err),
  .issue_valid(issue_valid),
  .issue_ready(issue_ready),
  .issue_simd (issue_simd),
  .issue_slot (issue_slot),
  .issue_pc   (issue_pc),
  .valid_all  (valid_all),
  .pend_all   (pend_all)
);

// File: tb/test_wave_issue_sched.sv
module test_wave_issue_sched;
  localparam int NS  = 4;
  localparam int NSL = 10;
  localparam int PW  = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alloc_valid = 0, free_valid = 0, pend_set_valid = 0, pend_clr_valid = 0;
  logic [1:0]    alloc_simd = 0, free_simd = 0, pend_set_simd = 0, pend_clr_simd = 0;
  logic [3:0]    alloc_slot = 0, free_slot = 0, pend_set_slot = 0, pend_clr_slot = 0;
  logic [PW-1:0] alloc_pc = 0;
  logic          alloc_err, issue_valid, issue_ready = 1'b1;
  logic [1:0]    issue_simd;
  logic [3:0]    issue_slot;
  logic [PW-1:0] issue_pc;

  wave_issue_sched i_wave_issue_sched (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit            mv [NS][NSL];
  bit            mp [NS][NSL];
  logic [PW-1:0] mpc [NS][NSL];
  int            mlast [NS];
  int            mturn;
  bit            ev, eerr;
  int            es, eslot;
  logic [PW-1:0] epc;
  int            last_new [NS];
  bit            out_seen, hold_edge;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: got %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int count_row(int s);
    int n = 0;
    for (int l = 0; l < NSL; l++) n += int'(mv[s][l]);
    return n;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin
      mlast[s] = NSL - 1;
      last_new[s] = -100;
      for (int l = 0; l < NSL; l++) begin mv[s][l] = 0; mp[s][l] = 0; end
    end
    mturn = 0; ev = 0; eerr = 0; out_seen = 0;
  endtask

  task automatic model_step();
    bit load;
    load = !ev || issue_ready;
    hold_edge = out_seen && !issue_ready;
    eerr = alloc_valid && (count_row(int'(alloc_simd)) == NSL);
    if (load) begin
      ev = 0;
      for (int k = NSL; k >= 1; k--) begin
        int c = (mlast[mturn] + k) % NSL;
        if (mv[mturn][c] && !mp[mturn][c]) begin ev = 1; eslot = c; end
      end
      es = mturn;
      if (ev) begin epc = mpc[mturn][eslot]; mlast[mturn] = eslot; end
      mturn = (mturn + 1) % NS;
    end
    if (alloc_valid && int'(alloc_slot) < NSL && !mv[alloc_simd][alloc_slot]) begin
      mv[alloc_simd][alloc_slot] = 1; mp[alloc_simd][alloc_slot] = 0;
      mpc[alloc_simd][alloc_slot] = alloc_pc;
    end
    if (pend_set_valid && int'(pend_set_slot) < NSL) mp[pend_set_simd][pend_set_slot] = 1;
    if (pend_clr_valid && int'(pend_clr_slot) < NSL) mp[pend_clr_simd][pend_clr_slot] = 0;
    if (free_valid && int'(free_slot) < NSL) begin
      mv[free_simd][free_slot] = 0; mp[free_simd][free_slot] = 0;
    end
  endtask

  task automatic compare();
    chk("R5 issue_valid", issue_valid, ev);
    if (ev) begin
      chk("R1 issue_simd", issue_simd, es);
      chk("R4 issue_slot", issue_slot, eslot);
      chk("R3 issue_pc", issue_pc, epc);
    end
    chk("R7 alloc_err", alloc_err, eerr);
    if (issue_valid && !hold_edge) begin
      chk("R2 issue gap", (cyc - last_new[issue_simd] >= 4), 1);
      last_new[issue_simd] = cyc;
    end
    out_seen = issue_valid;
  endtask

  task automatic idle();
    alloc_valid = 0; free_valid = 0; pend_set_valid = 0; pend_clr_valid = 0;
    issue_ready = 1;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc++;
    compare();
    idle();
  endtask

  task automatic do_alloc(int s, int l, logic [PW-1:0] pc);
    alloc_valid = 1; alloc_simd = 2'(s); alloc_slot = 4'(l); alloc_pc = pc;
    tick();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: reset state
    chk("R11 reset issue_valid", issue_valid, 0);
    chk("R11 reset alloc_err", alloc_err, 0);

    // R1 R3 R4 R5: two slots in SIMD 1, one in SIMD 2
    do_alloc(1, 0, 48'h1000);
    do_alloc(1, 3, 48'h1300);
    do_alloc(2, 5, 48'h2500);
    repeat (12) tick();

    // R6: pending excludes; set and clear together leaves the slot ready
    pend_set_valid = 1; pend_set_simd = 1; pend_set_slot = 0;
    tick();
    repeat (8) tick();
    pend_set_valid = 1; pend_set_simd = 1; pend_set_slot = 3;
    pend_clr_valid = 1; pend_clr_simd = 1; pend_clr_slot = 3;
    tick();
    repeat (8) tick();
    pend_clr_valid = 1; pend_clr_simd = 1; pend_clr_slot = 0;
    tick();
    repeat (8) tick();

    // R7: fill SIMD 3, then one more request is refused
    for (int l = 0; l < NSL; l++) do_alloc(3, l, 48'h3000 + 48'(l));
    do_alloc(3, 4, 48'hdead);
    chk("R7 full SIMD error", alloc_err, 1);
    tick();
    chk("R7 error lasts one cycle", alloc_err, 0);
    repeat (16) tick();

    // R8: occupied slot and out-of-range slot ignored
    do_alloc(2, 5, 48'hbad0);
    do_alloc(0, 12, 48'hbad1);
    repeat (12) tick();

    // R9: freeing removes the slot
    free_valid = 1; free_simd = 2; free_slot = 5;
    tick();
    repeat (12) tick();

    // R10: stalled consumer holds the pick
    issue_ready = 0; tick();
    for (int i = 0; i < 5; i++) begin issue_ready = 0; tick(); end
    repeat (8) tick();

    // random phase exercising all requests with random stalls
    for (int i = 0; i < 4000; i++) begin
      alloc_valid    = ($urandom % 4) == 0;
      alloc_simd     = 2'($urandom % NS);
      alloc_slot     = 4'($urandom % 12);
      alloc_pc       = {16'($urandom), 32'($urandom)};
      free_valid     = ($urandom % 9) == 0;
      free_simd      = 2'($urandom % NS);
      free_slot      = 4'($urandom % NSL);
      pend_set_valid = ($urandom % 3) == 0;
      pend_set_simd  = 2'($urandom % NS);
      pend_set_slot  = 4'($urandom % NSL);
      pend_clr_valid = ($urandom % 3) == 0;
      pend_clr_simd  = 2'($urandom % NS);
      pend_clr_slot  = 4'($urandom % NSL);
      issue_ready    = ($urandom % 4) != 0;
      tick();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule